// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Error Detection

This block turns an asynchronous serial line into parallel characters. The line is oversampled by a single-cycle enable pulse that arrives sixteen times per bit period. The block runs in the system clock domain throughout. The serial input first passes through a short synchronizer. A framing engine then finds the start bit, confirms it at its centre, and collects 5 to 8 data bits with the least significant bit first. It also takes an optional parity bit and the stop bit.

Each finished character is loaded into a receive buffer. Every character also updates a set of sticky status flags: data ready, overrun, parity error, framing error and break. Software-side logic consumes the results through two strobes. One strobe marks a read of the buffer and the other marks a read of the status. A freeze input parks the receiver on an idle line.

Top module: `uart_rx_core`

## Requirements
- R1: Each step of the framing engine happens on a `sample_en` pulse. The line, as seen after the synchronizer, is tested for a low start bit in the idle state. The start is confirmed by a second low sample on the 8th pulse after detection. Each following bit is sampled 16 pulses after the previous sample, and data arrives least significant bit first.
- R2: `word_len` selects the character size: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Buffer bits above the character size read as 0.
- R3: A start bit whose centre sample is high is discarded. No character is produced, and the receiver returns to idle to look for a new start.
- R4: Break is a character whose start, data, parity (when enabled) and stop samples are all low. It sets `break_det` and `framing_err`, and it loads 0x00 with data ready. The engine does not look for a new start until it has sampled the line high.
- R5: A stop sample that is low sets `framing_err`. Unless the character is a break, the engine goes straight back to looking for a start bit.
- R6: `overrun_err` is set when a character completes while `data_ready` is still 1 and no buffer read happens in that cycle. The buffer then holds the newer character.
- R7: `data_ready` is set in the cycle after a character completes. A `rd_data` strobe clears it, but a completion in the same cycle keeps it set.
- R8: Parity takes one bit after the data when `par_en` is 1. When `par_stick` is 0, an even-count check applies if `par_even` is 1, and an odd-count check applies if it is 0. When `par_stick` is 1, the expected parity bit is the inverse of `par_even`. A mismatch sets `parity_err`.
- R9: A `rd_status` strobe clears the overrun, parity, framing and break flags. An event that sets a flag in the same cycle takes priority over the clear.
- R10: After reset, `rx_data` is 0x00 and all flags are 0.
- R11: While `freeze` is 1, the engine is held idle and no character completes. A character in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle pulse at 16x the bit rate |
| freeze | input | 1 | Hold the receiver idle |
| ser_in | input | 1 | Asynchronous serial data, idle high |
| word_len | input | 2 | Character size code (00=5 .. 11=8) |
| par_en | input | 1 | Expect a parity bit |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Fixed parity bit select |
| rd_data | input | 1 | Buffer read strobe |
| rd_status | input | 1 | Status read strobe |
| rx_data | output | 8 | Receive buffer |
| data_ready | output | 1 | Unread character present |
| overrun_err | output | 1 | Character lost by overwrite |
| parity_err | output | 1 | Parity mismatch seen |
| framing_err | output | 1 | Stop sample was low |
| break_det | output | 1 | Whole character held low |

## Verification
The hardest state to reach from the ports is the recovery path after a break, which needs the line held low across a full character and then released. The stimulus builds the framing error and the false start from bit patterns rather than a stream of valid characters. The first is a stop bit driven low under nonzero data. The second is a short low glitch released before the start-bit centre. A behavioural model counts pulses from the start detection and is compared with every output on every clock. This exposes any slip of a single pulse in the sampling points.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 8;
    localparam int IDX_W  = $clog2(CHAR_W);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4,
        ST_MARK   = 3'd5
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_i,
    output logic line_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], ser_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign line_o = sh_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       freeze_i,
    input  logic       line_i,
    input  logic [1:0] word_len_i,
    input  logic       par_en_i,
    input  logic       par_even_i,
    input  logic       par_stick_i,
    output logic       done_o,
    output rx_char_t   char_o
);

    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] END_CNT = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [CHAR_W-1:0] shreg;
        logic              all_low;
        logic              par_bad;
    } frame_t;

    frame_t r_d, r_q;

    logic [IDX_W-1:0] last_idx;
    logic             at_mid, at_end, exp_par;
    logic [CNT_W-1:0] cnt_inc;

    assign last_idx = IDX_W'(4) + IDX_W'(word_len_i);
    assign at_mid   = (r_q.cnt == MID_CNT);
    assign at_end   = (r_q.cnt == END_CNT);
    assign cnt_inc  = r_q.cnt + 1'b1;
    assign exp_par  = par_stick_i ? ~par_even_i
                                  : (par_even_i ? ^r_q.shreg : ~^r_q.shreg);

    always_comb begin
        r_d         = r_q;
        done_o      = 1'b0;
        char_o.data = r_q.shreg;
        char_o.perr = r_q.par_bad;
        char_o.ferr = 1'b0;
        char_o.brk  = 1'b0;
        if (freeze_i) begin
            r_d.st = ST_IDLE;
        end else if (tick_i) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (!line_i) begin
                        r_d.st  = ST_START;
                        r_d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (at_mid) begin
                        if (line_i) begin
                            r_d.st = ST_IDLE;
                        end else begin
                            r_d.st      = ST_DATA;
                            r_d.cnt     = '0;
                            r_d.idx     = '0;
                            r_d.shreg   = '0;
                            r_d.all_low = 1'b1;
                            r_d.par_bad = 1'b0;
                        end
                    end else begin
                        r_d.cnt = cnt_inc;
                    end
                end
                ST_DATA: begin
                    r_d.cnt = cnt_inc;
                    if (at_end) begin
                        r_d.shreg[r_q.idx] = line_i;
                        r_d.all_low        = r_q.all_low & ~line_i;
                        if (r_q.idx == last_idx) begin
                            r_d.st = par_en_i ? ST_PARITY : ST_STOP;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end
                end
                ST_PARITY: begin
                    r_d.cnt = cnt_inc;
                    if (at_end) begin
                        r_d.par_bad = line_i ^ exp_par;
                        r_d.all_low = r_q.all_low & ~line_i;
                        r_d.st      = ST_STOP;
                    end
                end
                ST_STOP: begin
                    r_d.cnt = cnt_inc;
                    if (at_end) begin
                        done_o      = 1'b1;
                        char_o.ferr = ~line_i;
                        char_o.brk  = r_q.all_low & ~line_i;
                        r_d.st      = (r_q.all_low & ~line_i) ? ST_MARK : ST_IDLE;
                    end
                end
                ST_MARK: begin
                    if (line_i) r_d.st = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.cnt     <= '0;
            r_q.idx     <= '0;
            r_q.shreg   <= '0;
            r_q.all_low <= 1'b0;
            r_q.par_bad <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  rx_char_t          char_i,
    input  logic              rd_data_i,
    input  logic              rd_status_i,
    output logic [CHAR_W-1:0] data_o,
    output logic              dr_o,
    output logic              oe_o,
    output logic              pe_o,
    output logic              fe_o,
    output logic              bi_o
);

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              dr;
        logic              oe;
        logic              pe;
        logic              fe;
        logic              bi;
    } buf_t;

    buf_t b_d, b_q;
    logic keep;

    assign keep = ~rd_status_i;

    always_comb begin
        b_d    = b_q;
        b_d.oe = (b_q.oe & keep) | (done_i & b_q.dr & ~rd_data_i);
        b_d.pe = (b_q.pe & keep) | (done_i & char_i.perr);
        b_d.fe = (b_q.fe & keep) | (done_i & char_i.ferr);
        b_d.bi = (b_q.bi & keep) | (done_i & char_i.brk);
        if (done_i) begin
            b_d.data = char_i.data;
            b_d.dr   = 1'b1;
        end else if (rd_data_i) begin
            b_d.dr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign data_o = b_q.data;
    assign dr_o   = b_q.dr;
    assign oe_o   = b_q.oe;
    assign pe_o   = b_q.pe;
    assign fe_o   = b_q.fe;
    assign bi_o   = b_q.bi;

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_en,
    input  logic       freeze,
    input  logic       ser_in,
    input  logic [1:0] word_len,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] rx_data,
    output logic       data_ready,
    output logic       overrun_err,
    output logic       parity_err,
    output logic       framing_err,
    output logic       break_det
);

    logic     line;
    logic     char_done;
    rx_char_t char_word;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ser_i  (ser_in),
        .line_o (line)
    );

    uart_rx_frame #(.OSR(OSR)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (sample_en),
        .freeze_i    (freeze),
        .line_i      (line),
        .word_len_i  (word_len),
        .par_en_i    (par_en),
        .par_even_i  (par_even),
        .par_stick_i (par_stick),
        .done_o      (char_done),
        .char_o      (char_word)
    );

    uart_rx_buf u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (char_done),
        .char_i      (char_word),
        .rd_data_i   (rd_data),
        .rd_status_i (rd_status),
        .data_o      (rx_data),
        .dr_o        (data_ready),
        .oe_o        (overrun_err),
        .pe_o        (parity_err),
        .fe_o        (framing_err),
        .bi_o        (break_det)
    );

endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       freeze,
    input logic       rd_data,
    input logic       rd_status,
    input logic [1:0] word_len,
    input logic       done,
    input logic [7:0] rx_data,
    input logic       data_ready,
    input logic       overrun_err,
    input logic       parity_err,
    input logic       framing_err,
    input logic       break_det
);

    assert_dr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> data_ready);

    assert_dr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !done) |=> !data_ready);

    assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !done) |=> !(overrun_err || parity_err || framing_err || break_det));

    assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && data_ready && !rd_data) |=> overrun_err);

    assert_short_char_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && word_len == 2'b00) |=> (rx_data[7:5] == 3'b000));

    assert_break_frames_R4: assert property (@(posedge clk) disable iff (!rst_n)
        break_det && !$past(break_det) |-> framing_err && rx_data == 8'h00);

    assert_freeze_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !rd_data && !rd_status) |=>
            $stable({rx_data, data_ready, overrun_err, parity_err, framing_err, break_det}));

endmodule

bind uart_rx_core uart_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .freeze      (freeze),
    .rd_data     (rd_data),
    .rd_status   (rd_status),
    .word_len    (word_len),
    .done        (char_done),
    .rx_data     (rx_data),
    .data_ready  (data_ready),
    .overrun_err (overrun_err),
    .parity_err  (parity_err),
    .framing_err (framing_err),
    .break_det   (break_det)
);

// File: tb/tb_uart_rx_core.sv
`timescale 1ns/1ps
module tb_uart_rx_core;

    localparam int DIV   = 4;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       freeze = 1'b0;
    logic       ser_in = 1'b1;
    logic [1:0] word_len = 2'b11;
    logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
    logic       rd_data = 1'b0, rd_status = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready, overrun_err, parity_err, framing_err, break_det;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    uart_rx_core dut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .freeze(freeze),
        .ser_in(ser_in), .word_len(word_len), .par_en(par_en),
        .par_even(par_even), .par_stick(par_stick), .rd_data(rd_data),
        .rd_status(rd_status), .rx_data(rx_data), .data_ready(data_ready),
        .overrun_err(overrun_err), .parity_err(parity_err),
        .framing_err(framing_err), .break_det(break_det)
    );

    always #10 clk = ~clk;

    // 16x pulse source
    int pc = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            pc <= 0;
            sample_en <= 1'b0;
        end else begin
            pc <= (pc == DIV - 1) ? 0 : pc + 1;
            sample_en <= (pc == DIV - 1);
        end
    end

    // Behavioural reference: counts pulses since start detection
    logic       m_s1, m_s2;
    int         mode, p;
    logic [7:0] acc, m_data;
    logic       lowall, pbad;
    logic       m_dr, m_oe, m_pe, m_fe, m_bi;

    always @(posedge clk) begin
        logic line, done, c_fe, c_bi, expp;
        int k, nb;
        if (!rst_n) begin
            m_s1 = 1'b1; m_s2 = 1'b1; mode = 0; p = 0; acc = 8'h00;
            m_data = 8'h00; lowall = 1'b0; pbad = 1'b0;
            m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
        end else begin
            line = m_s2; m_s2 = m_s1; m_s1 = ser_in;
            done = 1'b0; c_fe = 1'b0; c_bi = 1'b0;
            if (freeze) begin
                mode = 0;
            end else if (sample_en) begin
                if (mode == 0) begin
                    if (!line) begin mode = 1; p = 0; end
                end else if (mode == 2) begin
                    if (line) mode = 0;
                end else begin
                    p++;
                    if (p == 8) begin
                        if (line) mode = 0;
                        else begin acc = 8'h00; lowall = 1'b1; pbad = 1'b0; end
                    end else if (p > 8 && (p - 8) % 16 == 0) begin
                        k = (p - 8) / 16 - 1;
                        nb = 5 + int'(word_len);
                        if (k < nb) begin
                            acc[k] = line;
                            if (line) lowall = 1'b0;
                        end else if (k == nb && par_en) begin
                            if (par_stick) expp = !par_even;
                            else expp = par_even ? ($countones(acc) % 2 == 1)
                                                 : ($countones(acc) % 2 == 0);
                            pbad = (line != expp);
                            if (line) lowall = 1'b0;
                        end else begin
                            done = 1'b1; c_fe = !line; c_bi = lowall && !line;
                            mode = c_bi ? 2 : 0;
                        end
                    end
                end
            end
            m_oe = (m_oe && !rd_status) || (done && m_dr && !rd_data);
            m_pe = (m_pe && !rd_status) || (done && pbad);
            m_fe = (m_fe && !rd_status) || c_fe;
            m_bi = (m_bi && !rd_status) || c_bi;
            if (done) begin m_data = acc; m_dr = 1'b1; end
            else if (rd_data) m_dr = 1'b0;
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            compared++;
            if (rx_data !== m_data || data_ready !== m_dr || overrun_err !== m_oe ||
                parity_err !== m_pe || framing_err !== m_fe || break_det !== m_bi) begin
                mismatched++;
                if (rx_data !== m_data)
                    $display("FAIL R1/R2 rx_data actual=%h expected=%h t=%0t", rx_data, m_data, $time);
                if (data_ready !== m_dr)
                    $display("FAIL R7 data_ready actual=%b expected=%b t=%0t", data_ready, m_dr, $time);
                if (overrun_err !== m_oe)
                    $display("FAIL R6 overrun actual=%b expected=%b t=%0t", overrun_err, m_oe, $time);
                if (parity_err !== m_pe)
                    $display("FAIL R8 parity actual=%b expected=%b t=%0t", parity_err, m_pe, $time);
                if (framing_err !== m_fe)
                    $display("FAIL R5 framing actual=%b expected=%b t=%0t", framing_err, m_fe, $time);
                if (break_det !== m_bi)
                    $display("FAIL R4 break actual=%b expected=%b t=%0t", break_det, m_bi, $time);
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_pulses(input int n);
        int c = 0;
        while (c < n) begin
            @(posedge clk);
            if (sample_en) c++;
        end
        @(negedge clk);
    endtask

    function automatic logic par_bit(input logic [7:0] d, input int n);
        int ones = 0;
        for (int i = 0; i < n; i++) ones += int'(d[i]);
        if (par_stick) return !par_even;
        return par_even ? (ones % 2 == 1) : (ones % 2 == 0);
    endfunction

    task automatic send_char(input logic [7:0] d, input bit flip_par, input logic stop_v);
        int n = 5 + int'(word_len);
        ser_in = 1'b0; wait_pulses(16);
        for (int i = 0; i < n; i++) begin ser_in = d[i]; wait_pulses(16); end
        if (par_en) begin ser_in = par_bit(d, n) ^ flip_par; wait_pulses(16); end
        ser_in = stop_v; wait_pulses(16);
        ser_in = 1'b1; wait_pulses(20);
    endtask

    task automatic read_all();
        rd_data = 1'b1; rd_status = 1'b1;
        @(negedge clk);
        rd_data = 1'b0; rd_status = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] flags();
        return {3'b000, data_ready, overrun_err, parity_err, framing_err, break_det};
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_data, 8'h00, "R10 reset buffer");
        chk(flags(), 8'h00, "R10 reset flags");

        // R1: plain 8-bit character, no parity
        send_char(8'hA5, 1'b0, 1'b1);
        chk(rx_data, 8'hA5, "R1 8-bit data");
        chk(flags(), 8'h10, "R7 data ready set");
        rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
        chk(flags(), 8'h00, "R7 data ready cleared by read");

        // R2: 5-bit character, upper bits zero
        word_len = 2'b00;
        send_char(8'hFF, 1'b0, 1'b1);
        chk(rx_data, 8'h1F, "R2 5-bit upper zero");
        read_all();
        word_len = 2'b10;
        send_char(8'h3C, 1'b0, 1'b1);
        chk(rx_data, 8'h3C, "R2 7-bit data");
        read_all();

        // R8: parity variants
        word_len = 2'b11; par_en = 1'b1; par_even = 1'b1;
        send_char(8'h37, 1'b0, 1'b1);
        chk(flags(), 8'h10, "R8 even parity good");
        read_all();
        send_char(8'h37, 1'b1, 1'b1);
        chk(flags(), 8'h14, "R8 even parity bad");
        read_all();
        chk(flags(), 8'h00, "R9 status read clears parity");
        par_even = 1'b0;
        send_char(8'h81, 1'b1, 1'b1);
        chk(flags(), 8'h14, "R8 odd parity bad");
        read_all();
        par_stick = 1'b1; par_even = 1'b1;
        send_char(8'h5A, 1'b0, 1'b1);
        chk(flags(), 8'h10, "R8 stick parity good");
        read_all();
        send_char(8'h5A, 1'b1, 1'b1);
        chk(flags(), 8'h14, "R8 stick parity bad");
        read_all();
        par_en = 1'b0; par_stick = 1'b0; par_even = 1'b0;

        // R5: framing error, then resynchronise on the next character
        send_char(8'h55, 1'b0, 1'b0);
        chk(rx_data, 8'h55, "R5 data with bad stop");
        chk(flags(), 8'h12, "R5 framing flag");
        read_all();
        send_char(8'hC3, 1'b0, 1'b1);
        chk(rx_data, 8'hC3, "R5 resync next char");
        chk(flags(), 8'h10, "R5 clean after resync");
        read_all();

        // R3: false start glitch
        ser_in = 1'b0; wait_pulses(5);
        ser_in = 1'b1; wait_pulses(200);
        chk(flags(), 8'h00, "R3 false start no char");
        chk(rx_data, 8'hC3, "R3 buffer untouched");

        // R6: overrun
        send_char(8'h11, 1'b0, 1'b1);
        send_char(8'h22, 1'b0, 1'b1);
        chk(rx_data, 8'h22, "R6 newer char kept");
        chk(flags(), 8'h18, "R6 overrun flag");
        read_all();
        chk(flags(), 8'h00, "R9 status read clears overrun");

        // R4: break, then wait for mark before next char
        ser_in = 1'b0; wait_pulses(16 * 14);
        chk(rx_data, 8'h00, "R4 break loads zero");
        chk(flags(), 8'h13, "R4 break and framing");
        read_all();
        wait_pulses(64);
        chk(flags(), 8'h00, "R4 no repeat while low");
        ser_in = 1'b1; wait_pulses(32);
        send_char(8'h96, 1'b0, 1'b1);
        chk(rx_data, 8'h96, "R4 receive after mark");
        read_all();

        // R11: freeze holds receiver idle
        freeze = 1'b1;
        send_char(8'h69, 1'b0, 1'b1);
        chk(flags(), 8'h00, "R11 freeze no char");
        chk(rx_data, 8'h96, "R11 buffer held");
        freeze = 1'b0; wait_pulses(8);
        send_char(8'hE7, 1'b0, 1'b1);
        chk(rx_data, 8'hE7, "R11 resumes after freeze");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL R1 watchdog actual=hung expected=complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule